// File: doc/BRIEF.md
# Coin-Operated Vending Controller

This block is a synchronous Moore state machine for a single-product vending point priced at 15 cents. It accepts two kinds of coin, 5 cents and 10 cents, each signalled by a one-cycle pulse on its own input line. It keeps the running balance as its state. When the balance reaches or passes the price, it enters a vend state for one cycle. In that cycle it raises a dispense strobe and shows the change owed on a small bus.

A clocked state register holds the balance. Separate combinational logic computes the next state from the current state and the selected coin. The outputs are decoded only from the registered state. A coin therefore shows up on the outputs one clock after the edge that samples it, never in the same cycle. A synchronous active-high reset returns the machine to the empty balance.

Top module: `vend_controller`

## Requirements
- R1: While reset is high at a clock edge, the next cycle shows an empty balance: dispense is 0 and change is 0.
- R2: A 5-cent pulse raises the balance by 5 cents. Three 5-cent coins in a row lead to a vend in the cycle after the third coin.
- R3: A 10-cent pulse raises the balance by 10 cents. From an empty balance, a 10-cent coin followed by a 5-cent coin leads to a vend.
- R4: When the balance reaches exactly 15 cents, the vend cycle shows dispense = 1 and change = 0.
- R5: When the balance reaches 20 cents (10 + 10), the vend cycle shows dispense = 1 and change = 5. The change bus is a 4-bit unsigned count of cents.
- R6: When both coin pulses arrive in the same cycle, only the 10-cent coin is counted and the 5-cent coin has no effect on the balance.
- R7: A vend cycle lasts exactly one clock. The machine then returns to the empty balance. If a coin arrives during the vend cycle, that coin is counted from an empty balance.
- R8: The outputs change only on the clock edge after a coin is sampled. A coin pulse does not alter dispense or change within its own cycle.
- R9: Change is 0 in every cycle in which dispense is 0.
- R10: A cycle with no coin pulse leaves a non-vend balance unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset to the empty balance |
| coinFive | input | 1 | One-cycle pulse for an inserted 5-cent coin |
| coinTen | input | 1 | One-cycle pulse for an inserted 10-cent coin |
| dispense | output | 1 | High for the single vend cycle |
| changeCents | output | 4 | Change owed in cents during a vend cycle, otherwise 0 |

## Verification
Two functions can coincide in one cycle. The vend cycle, which both dispenses and clears the balance, can meet a new coin, which starts the next purchase. Two coin pulses can also meet each other. The bench forces both cases directly, first with a 10-cent coin and then with a 5-cent coin driven in each vend cycle, and then with both coin lines pulsed together from every balance. A behavioural balance model judges each cycle: it clears a vend balance before adding the incoming coin, gives the 10-cent coin priority, and is compared with both outputs on every clock.

// File: rtl/vend_pkg.sv
package vend_pkg;

  // Balance states; binary encoded
  typedef enum logic [2:0] {
    ST_ZERO        = 3'd0,
    ST_FIVE        = 3'd1,
    ST_TEN         = 3'd2,
    ST_VEND_EXACT  = 3'd3,
    ST_VEND_CHANGE = 3'd4
  } vendState_t;

  // Coin accepted in the current cycle after arbitration
  typedef enum logic [1:0] {
    COIN_NONE  = 2'd0,
    COIN_SMALL = 2'd1,
    COIN_LARGE = 2'd2
  } coinSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic relStrobe;
    logic chgStrobe;
  } vendStrobe_t;

endpackage

// File: rtl/coin_arbiter.sv
module coin_arbiter
  import vend_pkg::*;
(
  input  logic     coinFive,
  input  logic     coinTen,
  output coinSel_t coinSel
);

  // The larger coin wins when both pulse together
  always_comb begin
    if (coinTen)       coinSel = COIN_LARGE;
    else if (coinFive) coinSel = COIN_SMALL;
    else               coinSel = COIN_NONE;
  end

endmodule

// File: rtl/vend_control.sv
module vend_control
  import vend_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  coinSel_t    coinSel,
  output vendStrobe_t strobes
);

  vendState_t curState;
  vendState_t nxtState;
  vendState_t baseState;

  // A vend state drops its balance before the new coin is counted
  always_comb begin
    unique case (curState)
      ST_FIVE: baseState = ST_FIVE;
      ST_TEN:  baseState = ST_TEN;
      default: baseState = ST_ZERO;
    endcase
  end

  always_comb begin
    nxtState = baseState;
    unique case (baseState)
      ST_ZERO: begin
        if (coinSel == COIN_LARGE)      nxtState = ST_TEN;
        else if (coinSel == COIN_SMALL) nxtState = ST_FIVE;
      end
      ST_FIVE: begin
        if (coinSel == COIN_LARGE)      nxtState = ST_VEND_EXACT;
        else if (coinSel == COIN_SMALL) nxtState = ST_TEN;
      end
      ST_TEN: begin
        if (coinSel == COIN_LARGE)      nxtState = ST_VEND_CHANGE;
        else if (coinSel == COIN_SMALL) nxtState = ST_VEND_EXACT;
      end
      default: nxtState = ST_ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_ZERO;
    else     curState <= nxtState;
  end

  // Moore decode: strobes come from the registered state only
  always_comb begin
    strobes.relStrobe = (curState == ST_VEND_EXACT) || (curState == ST_VEND_CHANGE);
    strobes.chgStrobe = (curState == ST_VEND_CHANGE);
  end

  // R1: reset leads to empty balance
  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> curState == ST_ZERO);

  // R6: simultaneous coins from five cents count only the ten
  assert_large_priority_R6: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_FIVE && coinSel == COIN_LARGE) |=> curState == ST_VEND_EXACT);

  // R5: ten plus ten gives the change state
  assert_over_price_R5: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_TEN && coinSel == COIN_LARGE) |=> curState == ST_VEND_CHANGE);

  // R7: a vend state never follows itself
  assert_vend_once_R7: assert property (@(posedge clk) disable iff (rst)
    strobes.relStrobe |=> !strobes.relStrobe);

  // R10: no coin holds a non-vend balance
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!strobes.relStrobe && coinSel == COIN_NONE) |=> $stable(curState));

endmodule

// File: rtl/vend_datapath.sv
module vend_datapath
  import vend_pkg::*;
#(
  parameter int CHANGE_W     = 4,
  parameter int CHANGE_CENTS = 5
) (
  input  vendStrobe_t         strobes,
  output logic                dispense,
  output logic [CHANGE_W-1:0] changeCents
);

  localparam logic [CHANGE_W-1:0] ChangeVal = CHANGE_W'(CHANGE_CENTS);

  always_comb begin
    dispense    = strobes.relStrobe;
    changeCents = strobes.chgStrobe ? ChangeVal : '0;
  end

endmodule

// File: rtl/vend_controller.sv
module vend_controller
  import vend_pkg::*;
#(
  parameter int CHANGE_W   = 4,
  parameter int SMALL_COIN = 5,
  parameter int LARGE_COIN = 10,
  parameter int PRICE      = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                coinFive,
  input  logic                coinTen,
  output logic                dispense,
  output logic [CHANGE_W-1:0] changeCents
);

  localparam int OverPay = 2 * LARGE_COIN - PRICE;

  coinSel_t    coinSel;
  vendStrobe_t strobes;

  coin_arbiter u_arb (
    .coinFive(coinFive),
    .coinTen (coinTen),
    .coinSel (coinSel)
  );

  vend_control u_ctl (
    .clk    (clk),
    .rst    (rst),
    .coinSel(coinSel),
    .strobes(strobes)
  );

  vend_datapath #(
    .CHANGE_W    (CHANGE_W),
    .CHANGE_CENTS(OverPay)
  ) u_dp (
    .strobes    (strobes),
    .dispense   (dispense),
    .changeCents(changeCents)
  );

  // R9: change is shown only while dispensing
  assert_change_gated_R9: assert property (@(posedge clk) disable iff (rst)
    !dispense |-> changeCents == '0);

  // R4: five then ten from empty is an exact vend
  assert_exact_vend_R4: assert property (@(posedge clk) disable iff (rst)
    (dispense && changeCents == '0) |-> $past(coinTen || coinFive));

  // R8: a vend requires a coin sampled on the previous edge
  assert_moore_latency_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(dispense) |-> $past(coinFive || coinTen));

endmodule

// File: tb/sim_vend_controller.sv
module sim_vend_controller;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       coinFive = 1'b0;
  logic       coinTen = 1'b0;
  logic       dispense;
  logic [3:0] changeCents;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int balance = 0;
  bit modelValid = 1'b0;
  string curReq = "R1";

  always #10 clk = ~clk;  // 50 MHz

  vend_controller u0 (
    .clk        (clk),
    .rst        (rst),
    .coinFive   (coinFive),
    .coinTen    (coinTen),
    .dispense   (dispense),
    .changeCents(changeCents)
  );

  // Behavioural balance model
  always @(posedge clk) begin
    int base;
    if (rst) balance <= 0;
    else begin
      base = (balance >= 15) ? 0 : balance;
      if (coinTen)       balance <= base + 10;
      else if (coinFive) balance <= base + 5;
      else               balance <= base;
    end
    modelValid <= 1'b1;
  end

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    int expD;
    int expC;
    if (modelValid) begin
      expD = (balance >= 15) ? 1 : 0;
      expC = (balance >= 15) ? balance - 15 : 0;
      checks++;
      if (dispense !== expD[0] || changeCents !== expC[3:0]) begin
        failures++;
        $display("FAIL %s: dispense=%0b change=%0d expected dispense=%0d change=%0d",
                 curReq, dispense, changeCents, expD, expC);
      end
    end
  end

  task automatic coin(input bit f, input bit t);
    @(negedge clk);
    coinFive = f;
    coinTen  = t;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) coin(1'b0, 1'b0);
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    curReq = "R1";
    idle(3);
    @(negedge clk); rst = 1'b0;
    idle(2);

    curReq = "R2";  coin(1,0); coin(1,0); coin(1,0); idle(2);
    curReq = "R3";  coin(0,1); coin(1,0); idle(2);
    curReq = "R4";  coin(1,0); coin(0,1); idle(2);
    curReq = "R5";  coin(0,1); coin(0,1); idle(2);
    curReq = "R6";  coin(1,1); idle(1); coin(1,1); idle(1);
    coin(1,0); coin(1,1); idle(2);
    curReq = "R7";  coin(0,1); coin(0,1); coin(0,1); coin(1,0); idle(2);
    coin(0,1); coin(1,0); coin(1,0); coin(1,0); idle(2);
    curReq = "R8";  coin(1,0); coin(0,0); coin(0,1); idle(1);
    curReq = "R10"; coin(1,0); idle(4); coin(1,0); idle(4); coin(1,0); idle(2);
    curReq = "R1";  coin(0,1); @(negedge clk); rst = 1'b1; coinTen = 1'b0;
    idle(1); @(negedge clk); rst = 1'b0; idle(2);

    curReq = "R9";
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom_range(0, 7);
      coin(r[0], r[1] & r[2]);
    end
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule